// File: doc/BRIEF.md
# Debug Monitor Mode Entry Controller

This block decides when a small CPU core switches into its debug monitor mode, and it drives every side effect of that mode at the same moment. While the reset input is low, the block samples two straps on every clock: a high-voltage detect flag and an active-low clock-bypass strap. The values seen at the release of reset are then held until the next reset. If the high-voltage flag was latched high, monitor mode starts as reset is released. In user mode, a software-interrupt event also starts monitor mode.

While the block is in monitor mode, it remaps vector fetches at the top of the address space to an alternate page. It holds the watchdog off and can remove the divide-by-two stage from the bus clock enable. It also sends a break on the serial transmit line, so that a host can detect the bit rate. The block is built around one state machine with these states:

- `ST_RESET`: reset is held low.
- `ST_USER`: normal operation.
- `ST_BREAK`: ten low bit times are sent.
- `ST_GAP`: one idle high bit time is sent.
- `ST_DONE`: a one-cycle done pulse is raised.
- `ST_READY`: the block waits in monitor mode for a host command.

The state machine takes these transitions:

- `ST_RESET` goes to `ST_BREAK` or to `ST_USER` on release, according to the latched high-voltage flag.
- `ST_USER` goes to `ST_BREAK` on a software interrupt.
- `ST_BREAK` goes to `ST_GAP` at the end of the tenth bit.
- `ST_GAP` goes to `ST_DONE` at the end of the idle bit.
- `ST_DONE` always goes to `ST_READY`.
- Any state goes to `ST_RESET` while `rst_n` is low.

Top module: `mon_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, `hv_det` and `clk_byp_n` are sampled on each clock. The values present at reset release are held until the next reset, and later changes on those inputs have no effect. At release, `mon_active` becomes 1 on the first clock edge if the latched `hv_det` is 1; otherwise it stays 0.
- R2: In user mode, a one-cycle `swi_evt` sets `mon_active` on the next clock edge. During that same cycle the vector output is not yet remapped. A `swi_evt` that arrives while the block is already in monitor mode does not restart the break and leaves `txd` high once the break is over.
- R3: From the first cycle of monitor mode, `txd` stays 0 for exactly 10 bit times. One bit time is `bit_div`+1 clock cycles.
- R4: After the break, `txd` returns to 1 and stays there. `brk_done` is high for exactly one cycle, which starts one bit time after `txd` went high.
- R5: In monitor mode, the addresses 0xFFFA–0xFFFF are mapped to 0xFEFA–0xFEFF. These are the break vector (low byte FA/FB), the software-interrupt vector (FC/FD) and the reset vector (FE/FF). Only the high byte changes.
- R6: All other addresses pass through unchanged, and no address is remapped outside monitor mode.
- R7: `wdog_en` is 0 when the block is in monitor mode and the latched `hv_det` is 1. In every other case `wdog_en` equals `cfg_wdog_en`.
- R8: When the block is in monitor mode and the latched `clk_byp_n` is 0, `bus_ce` is 1 on every cycle and `div_bypassed` is 1. Otherwise `bus_ce` alternates between 1 and 0 on each cycle and `div_bypassed` is 0.
- R9: Monitor mode stays active until a reset. A reset released with `hv_det` low returns the block to user mode, in which `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously |
| hv_det | input | 1 | High-voltage detect strap |
| clk_byp_n | input | 1 | Clock-bypass strap, low selects undivided bus clock in monitor mode |
| swi_evt | input | 1 | Software-interrupt executed, one-cycle pulse |
| cfg_wdog_en | input | 1 | Normal watchdog enable setting |
| bit_div | input | DIV_W | Bit time minus one, in clock cycles |
| vec_addr_in | input | ADDR_W | Fetch address from the core |
| vec_addr_out | output | ADDR_W | Fetch address after vector remapping |
| mon_active | output | 1 | Monitor mode is active |
| wdog_en | output | 1 | Watchdog enable to the watchdog |
| bus_ce | output | 1 | Bus clock enable |
| div_bypassed | output | 1 | Divide-by-two stage bypassed |
| txd | output | 1 | Serial transmit line |
| brk_done | output | 1 | Break finished, one-cycle pulse |

## Verification
Two functions can land in the same cycle: a software interrupt that enters monitor mode, and a fetch of the software-interrupt vector. The bench raises `swi_evt` while it presents 0xFFFC on the address input. It then expects the address to pass through unchanged in that cycle and to be remapped to 0xFEFC in the next cycle. In that next cycle `txd` must also be low, because it is the first cycle of the break. Random trials also vary the bit divider, both straps and the entry path. These trials check that the break timing, the watchdog gating and the clock enable all change together on the entry edge.

// File: rtl/mon_pkg.sv
package mon_pkg;
    typedef enum logic [2:0] {
        ST_RESET,
        ST_USER,
        ST_BREAK,
        ST_GAP,
        ST_DONE,
        ST_READY
    } mon_state_t;

    localparam int         BRK_BITS   = 10;
    localparam logic [7:0] MON_PAGE   = 8'hFE;
    localparam logic [7:0] USR_PAGE   = 8'hFF;
    localparam logic [7:0] VEC_LO_MIN = 8'hFA;
endpackage

// File: rtl/mon_bit_timer.sv
module mon_bit_timer #(
    parameter int DIV_W = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic [CNT_W-1:0] bits
);
    logic [DIV_W-1:0] cyc;

    assign tick = en && (cyc == div);

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cyc  <= '0;
            bits <= '0;
        end else if (tick) begin
            cyc  <= '0;
            bits <= bits + 1'b1;
        end else begin
            cyc  <= cyc + 1'b1;
        end
    end

    // R3
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cyc == '0));
endmodule

// File: rtl/mon_vec_remap.sv
module mon_vec_remap #(
    parameter int ADDR_W = 16
) (
    input  logic              active,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    import mon_pkg::*;

    logic is_vec;

    always_comb begin
        is_vec = (addr_in[ADDR_W-1:8] == {{(ADDR_W-16){1'b0}}, USR_PAGE})
              && (addr_in[7:0] >= VEC_LO_MIN);
        addr_out = addr_in;
        if (active && is_vec) begin
            addr_out[15:8] = MON_PAGE;
        end
    end
endmodule

// File: rtl/mon_clk_div.sv
module mon_clk_div (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass,
    output logic bus_ce
);
    logic ph;

    always_ff @(posedge clk) begin
        if (!rst_n) ph <= 1'b0;
        else        ph <= ~ph;
    end

    assign bus_ce = bypass ? 1'b1 : ph;

    // R8
    div_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && $past(!bypass) && $past(rst_n)) |-> (bus_ce != $past(bus_ce)));
endmodule

// File: rtl/mon_entry_ctrl.sv
module mon_entry_ctrl #(
    parameter int DIV_W  = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_det,
    input  logic              clk_byp_n,
    input  logic              swi_evt,
    input  logic              cfg_wdog_en,
    input  logic [DIV_W-1:0]  bit_div,
    input  logic [ADDR_W-1:0] vec_addr_in,
    output logic [ADDR_W-1:0] vec_addr_out,
    output logic              mon_active,
    output logic              wdog_en,
    output logic              bus_ce,
    output logic              div_bypassed,
    output logic              txd,
    output logic              brk_done
);
    import mon_pkg::*;

    localparam int CNT_W = $clog2(BRK_BITS + 1);

    mon_state_t       state, nxt;
    logic             hv_q, byp_q;
    logic             tmr_en, tmr_tick;
    logic [CNT_W-1:0] tmr_bits;

    // Strap capture: transparent during reset, frozen after release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hv_q  <= hv_det;
            byp_q <= clk_byp_n;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET: nxt = hv_q ? ST_BREAK : ST_USER;
            ST_USER:  if (swi_evt) nxt = ST_BREAK;
            ST_BREAK: if (tmr_tick && tmr_bits == CNT_W'(BRK_BITS - 1)) nxt = ST_GAP;
            ST_GAP:   if (tmr_tick) nxt = ST_DONE;
            ST_DONE:  nxt = ST_READY;
            ST_READY: nxt = ST_READY;
            default:  nxt = ST_RESET;
        endcase
    end

    // Outputs
    always_comb begin
        mon_active = 1'b0;
        txd        = 1'b1;
        brk_done   = 1'b0;
        tmr_en     = 1'b0;
        unique case (state)
            ST_RESET, ST_USER: ;
            ST_BREAK: begin mon_active = 1'b1; txd = 1'b0; tmr_en = 1'b1; end
            ST_GAP:   begin mon_active = 1'b1; tmr_en = 1'b1; end
            ST_DONE:  begin mon_active = 1'b1; brk_done = 1'b1; end
            ST_READY: mon_active = 1'b1;
            default:  ;
        endcase
        wdog_en      = (mon_active && hv_q) ? 1'b0 : cfg_wdog_en;
        div_bypassed = mon_active && !byp_q;
    end

    mon_bit_timer #(.DIV_W(DIV_W), .CNT_W(CNT_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .en(tmr_en), .div(bit_div),
        .tick(tmr_tick), .bits(tmr_bits)
    );

    mon_vec_remap #(.ADDR_W(ADDR_W)) i_remap (
        .active(mon_active), .addr_in(vec_addr_in), .addr_out(vec_addr_out)
    );

    mon_clk_div i_clkdiv (
        .clk(clk), .rst_n(rst_n), .bypass(div_bypassed), .bus_ce(bus_ce)
    );

    // R1
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(hv_q) && $stable(byp_q)));

    // R9
    mon_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mon_active |=> mon_active);

    // R3
    entry_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mon_active) |-> !txd);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_done |=> (!brk_done && txd));
endmodule

// File: tb/test_mon_entry_ctrl.sv
`timescale 1ns/1ps
module test_mon_entry_ctrl;
    localparam int DIV_W = 8;

    logic        clk = 1'b0;
    logic        rst_n, hv_det, clk_byp_n, swi_evt, cfg_wdog_en;
    logic [7:0]  bit_div;
    logic [15:0] vec_addr_in, vec_addr_out;
    logic        mon_active, wdog_en, bus_ce, div_bypassed, txd, brk_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mon_entry_ctrl #(.DIV_W(DIV_W), .ADDR_W(16)) i_mon_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .hv_det(hv_det), .clk_byp_n(clk_byp_n),
        .swi_evt(swi_evt), .cfg_wdog_en(cfg_wdog_en), .bit_div(bit_div),
        .vec_addr_in(vec_addr_in), .vec_addr_out(vec_addr_out),
        .mon_active(mon_active), .wdog_en(wdog_en), .bus_ce(bus_ce),
        .div_bypassed(div_bypassed), .txd(txd), .brk_done(brk_done)
    );

    function automatic logic [15:0] exp_addr(input logic mon, input logic [15:0] a);
        if (mon && a[15:8] == 8'hFF && a[7:0] >= 8'hFA) return {8'hFE, a[7:0]};
        return a;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic check_addrs(input logic mon);
        logic [15:0] a;
        for (int i = 0; i < 10; i++) begin
            if (i < 6) a = 16'hFFFA + 16'(i);
            else       a = 16'($urandom);
            vec_addr_in = a;
            #0.1;
            check(mon ? "R5" : "R6", vec_addr_out, exp_addr(mon, a));
        end
        foreach (a[k]) ;
        vec_addr_in = 16'hFFF8;
        #0.1;
        check("R6", vec_addr_out, 16'hFFF8);
    endtask

    task automatic check_ce(input logic exp_byp);
        int ones = 0;
        check("R8", div_bypassed, exp_byp);
        for (int i = 0; i < 8; i++) begin
            ones += bus_ce;
            step();
        end
        check("R8", ones, exp_byp ? 8 : 4);
    endtask

    task automatic trial(input logic hv, input logic byp_n, input logic cfg,
                         input int div, input logic use_swi);
        int n, m;
        logic mon;
        step();
        rst_n = 1'b0; hv_det = hv; clk_byp_n = byp_n; cfg_wdog_en = cfg;
        bit_div = 8'(div); swi_evt = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // later strap changes must not matter
        hv_det = ~hv; clk_byp_n = ~byp_n;
        check("R1", mon_active, hv);
        mon = hv;
        if (!hv) begin
            check("R9", txd, 1'b1);
            check("R7", wdog_en, cfg);
            check_addrs(1'b0);
            check_ce(1'b0);
            if (use_swi) begin
                swi_evt = 1'b1; vec_addr_in = 16'hFFFC;
                #0.1;
                check("R2", vec_addr_out, 16'hFFFC);
                step();
                swi_evt = 1'b0;
                #0.1;
                check("R2", mon_active, 1'b1);
                check("R2", vec_addr_out, 16'hFEFC);
                mon = 1'b1;
            end
        end
        if (mon) begin
            n = 0;
            while (!txd && n < 3000) begin n++; step(); end
            check("R3", n, 10 * (div + 1));
            m = 0;
            while (!brk_done && m < 3000) begin
                if (!txd) check("R4", txd, 1'b1);
                m++; step();
            end
            check("R4", m, div + 1);
            step();
            check("R4", brk_done, 1'b0);
            check("R7", wdog_en, hv ? 1'b0 : cfg);
            check_addrs(1'b1);
            check_ce(!byp_n);
            swi_evt = 1'b1; step(); swi_evt = 1'b0;
            for (int i = 0; i < 4; i++) begin
                if (!txd || !mon_active) check("R2", {txd, mon_active}, 2'b11);
                step();
            end
            check("R2", {txd, mon_active}, 2'b11);
            check("R9", mon_active, 1'b1);
        end
    endtask

    initial begin
        rst_n = 1'b0; hv_det = 1'b0; clk_byp_n = 1'b1; swi_evt = 1'b0;
        cfg_wdog_en = 1'b1; bit_div = 8'd1; vec_addr_in = 16'h0000;
        void'($urandom(32'd4711));
        repeat (3) step();
        // directed corners
        trial(1'b0, 1'b1, 1'b1, 0, 1'b0);
        trial(1'b1, 1'b0, 1'b1, 0, 1'b0);
        trial(1'b0, 1'b0, 1'b1, 2, 1'b1);
        trial(1'b1, 1'b1, 1'b0, 3, 1'b0);
        trial(1'b0, 1'b1, 1'b1, 1, 1'b0);
        // constrained random
        for (int t = 0; t < 14; t++) begin
            trial(1'($urandom), 1'($urandom), 1'($urandom),
                  int'($urandom_range(0, 5)), 1'($urandom));
        end
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule